// File: doc/BRIEF.md
# Load Width Select and Sign Extend

This block shapes the raw contents of one 64-bit data-memory cell into the value that a load writes back to the register file. The memory is organised as doubleword cells, so the low three bits of the byte address do not reach the memory. Here they choose a 32-bit half or a single byte inside the fetched cell. A 2-bit size code, encoded like the low bits of the load funct3 field, selects the result. That result is either the whole cell unchanged, or the chosen word or byte widened to 64 bits by copying its top bit.

A final two-way selector picks between this shaped memory value and the ALU result, so the block's output feeds the register write port directly. The logic is purely combinational. It has no clock and no reset, and every output follows its inputs within the same cycle. Byte lanes are little-endian: byte k of a cell occupies bits [8k+7:8k].

Top module: `load_align_unit`

## Requirements
- R1: With `mem_sel`=1 and `size_code`=2'b11, `wb_data` equals `cell_data` exactly for every value of `addr_lo`.
- R2: With `mem_sel`=1, `size_code`=2'b10 and `addr_lo[2]`=0, `wb_data[31:0]` equals `cell_data[31:0]`.
- R3: With `mem_sel`=1, `size_code`=2'b10 and `addr_lo[2]`=1, `wb_data[31:0]` equals `cell_data[63:32]`.
- R4: For a word result, each bit of `wb_data[63:32]` equals bit 31 of the selected word. For example, a selected word 0xFFFF8000 gives 0xFFFFFFFFFFFF8000.
- R5: With `mem_sel`=1 and `size_code`=2'b00, `wb_data[7:0]` equals byte number `addr_lo` of the cell, that is bits [8*addr_lo+7 : 8*addr_lo]. `addr_lo[2]` picks the word and `addr_lo[1:0]` picks the byte inside it. Bits [63:8] all copy bit 7 of that byte.
- R6: With `mem_sel`=1 and `size_code`=2'b01, `wb_data` is zero.
- R7: With `mem_sel`=0, `wb_data` equals `alu_result`, whatever the other inputs are.
- R8: A word result does not depend on `addr_lo[1:0]`.
- R9: For a cell holding 0xFFFF8000_00000007, a word load returns 0xFFFFFFFFFFFF8000 at byte address 4 and 0x0000000000000007 at byte address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cell_data | input | 64 | Contents of the addressed memory cell |
| addr_lo | input | 3 | Byte offset of the access inside the cell |
| size_code | input | 2 | Access width: 00 byte, 01 unused, 10 word, 11 doubleword |
| mem_sel | input | 1 | 1 selects the memory value, 0 the ALU result |
| alu_result | input | 64 | ALU output offered as the alternative write-back value |
| wb_data | output | 64 | Value for the register write port |

## Verification
The assertions are immediate checks evaluated whenever the inputs change. They assume every input carries a known 0/1 value, and each check is skipped while any input holds X or Z. The stimulus drives only fully known values, on a cycle boundary, and reads the output half a period later. By then the combinational paths have settled, so no assertion sees an intermediate value. The sweep covers every offset, every size code and both selector values, against cells that place distinct, sign-varying data in each byte lane.

// File: rtl/load_align_pkg.sv
// Package: shared size encoding for the load shaping path.
// Assumes the size code follows the low bits of the load funct3 field.
package load_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_NONE  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } ld_size_e;

endpackage

// File: rtl/lane_pick.sv
// Module: lane_pick
// Splits a wide vector into equal little-endian lanes and returns the lane
// numbered by idx. Assumes IN_W is a whole multiple of LANE_W and that the
// lane count is a power of two, so every idx value names a real lane.
module lane_pick #(
    parameter int IN_W   = 64,
    parameter int LANE_W = 32,
    parameter int IDX_W  = 1
) (
    input  logic [IN_W-1:0]   src,
    input  logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] lane
);

    localparam int LANES = IN_W / LANE_W;

    logic [LANE_W-1:0] lanes [LANES];

    // One slice per lane, lane 0 at the least significant end.
    for (genvar g = 0; g < LANES; g++) begin : g_slice
        assign lanes[g] = src[g*LANE_W +: LANE_W];
    end

    // Route the indexed lane to the output.
    always_comb begin
        lane = lanes[idx];
    end

endmodule

// File: rtl/sign_widen.sv
// Module: sign_widen
// Widens a narrow value to OUT_W bits by copying its top bit upward.
// Assumes OUT_W is strictly greater than IN_W.
module sign_widen #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  narrow,
    output logic [OUT_W-1:0] wide
);

    localparam int FILL_W = OUT_W - IN_W;

    // Replicate the sign bit into the upper part.
    always_comb begin
        wide = {{FILL_W{narrow[IN_W-1]}}, narrow};
    end

endmodule

// File: rtl/size_select.sv
// Module: size_select
// Picks the shaped memory value from the three width candidates according
// to the size code. The unused code yields zero. Assumes the candidates are
// already widened to DATA_W.
module size_select
    import load_align_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] full_val,
    input  logic [DATA_W-1:0] word_val,
    input  logic [DATA_W-1:0] byte_val,
    input  logic [1:0]        size_code,
    output logic [DATA_W-1:0] mem_val
);

    ld_size_e sz;

    // Interpret the raw code through the shared encoding.
    always_comb begin
        sz = ld_size_e'(size_code);
    end

    // Width multiplexer.
    always_comb begin
        unique case (sz)
            SZ_DWORD: mem_val = full_val;
            SZ_WORD:  mem_val = word_val;
            SZ_BYTE:  mem_val = byte_val;
            default:  mem_val = '0;
        endcase
    end

endmodule

// File: rtl/load_align_unit.sv
// Module: load_align_unit (top)
// Turns one fetched memory cell into a register write-back value: it selects
// a word or byte by the low address bits, sign-extends it, or passes the
// whole cell, then chooses between that and the ALU result.
// Assumes: purely combinational use, inputs known, little-endian byte lanes,
// and a cell width that is a power-of-two multiple of the word and byte widths.
module load_align_unit #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int OFF_W  = $clog2(DATA_W / BYTE_W)
) (
    input  logic [DATA_W-1:0] cell_data,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [1:0]        size_code,
    input  logic              mem_sel,
    input  logic [DATA_W-1:0] alu_result,
    output logic [DATA_W-1:0] wb_data
);

    localparam int WORD_IDX_W = $clog2(DATA_W / WORD_W);
    localparam int SIGN_FILL  = DATA_W - BYTE_W + 1;

    logic [WORD_IDX_W-1:0] word_idx;
    logic [WORD_W-1:0]     word_raw;
    logic [BYTE_W-1:0]     byte_raw;
    logic [DATA_W-1:0]     word_ext;
    logic [DATA_W-1:0]     byte_ext;
    logic [DATA_W-1:0]     mem_val;

    // Top offset bits name the word within the cell.
    always_comb begin
        word_idx = addr_lo[OFF_W-1 -: WORD_IDX_W];
    end

    lane_pick #(
        .IN_W   (DATA_W),
        .LANE_W (WORD_W),
        .IDX_W  (WORD_IDX_W)
    ) word_pick_i (
        .src  (cell_data),
        .idx  (word_idx),
        .lane (word_raw)
    );

    lane_pick #(
        .IN_W   (DATA_W),
        .LANE_W (BYTE_W),
        .IDX_W  (OFF_W)
    ) byte_pick_i (
        .src  (cell_data),
        .idx  (addr_lo),
        .lane (byte_raw)
    );

    sign_widen #(
        .IN_W  (WORD_W),
        .OUT_W (DATA_W)
    ) word_widen_i (
        .narrow (word_raw),
        .wide   (word_ext)
    );

    sign_widen #(
        .IN_W  (BYTE_W),
        .OUT_W (DATA_W)
    ) byte_widen_i (
        .narrow (byte_raw),
        .wide   (byte_ext)
    );

    size_select #(
        .DATA_W (DATA_W)
    ) size_sel_i (
        .full_val  (cell_data),
        .word_val  (word_ext),
        .byte_val  (byte_ext),
        .size_code (size_code),
        .mem_val   (mem_val)
    );

    // Write-back source selection: memory value or ALU result.
    always_comb begin
        wb_data = mem_sel ? mem_val : alu_result;
    end

    // Guard the output against the inputs once all values are known.
    always_comb begin
        if (!$isunknown({cell_data, addr_lo, size_code, mem_sel, alu_result})) begin
            a_r7_alu_passthru: assert (mem_sel || wb_data == alu_result)
                else $error("R7: ALU result not passed through");
            a_r1_full_cell: assert (!(mem_sel && size_code == 2'b11) || wb_data == cell_data)
                else $error("R1: doubleword result differs from cell");
            a_r6_unused_zero: assert (!(mem_sel && size_code == 2'b01) || wb_data == '0)
                else $error("R6: unused size code not zero");
            a_r2_r3_word_lane: assert (!(mem_sel && size_code == 2'b10)
                    || wb_data[WORD_W-1:0] == cell_data[word_idx*WORD_W +: WORD_W])
                else $error("R2/R3: wrong word half");
            a_r4_word_sign: assert (!(mem_sel && size_code == 2'b10)
                    || $countones(wb_data[DATA_W-1:WORD_W-1]) == 0
                    || $countones(wb_data[DATA_W-1:WORD_W-1]) == DATA_W - WORD_W + 1)
                else $error("R4: word sign fill broken");
            a_r5_byte_sign: assert (!(mem_sel && size_code == 2'b00)
                    || $countones(wb_data[DATA_W-1:BYTE_W-1]) == 0
                    || $countones(wb_data[DATA_W-1:BYTE_W-1]) == SIGN_FILL)
                else $error("R5: byte sign fill broken");
        end
    end

endmodule

// File: tb/load_align_unit_tb_top.sv
// Bench: sweeps offsets, size codes and selector over a set of cell
// patterns and compares against arithmetic expectations.
module load_align_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic [63:0] cell_data  = '0;
    logic [2:0]  addr_lo    = '0;
    logic [1:0]  size_code  = '0;
    logic        mem_sel    = 1'b0;
    logic [63:0] alu_result = '0;
    logic [63:0] wb_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_align_unit dut_i (
        .cell_data  (cell_data),
        .addr_lo    (addr_lo),
        .size_code  (size_code),
        .mem_sel    (mem_sel),
        .alu_result (alu_result),
        .wb_data    (wb_data)
    );

    task automatic compare(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (cell=%h off=%0d size=%b sel=%b)",
                     tag, act, exp, cell_data, addr_lo, size_code, mem_sel);
        end
    endtask

    // Drive after a rising edge, sample on the falling edge.
    task automatic apply(input logic [63:0] c, input logic [2:0] a, input logic [1:0] s,
                         input logic m, input logic [63:0] alu);
        @(posedge clk);
        #1;
        cell_data  = c;
        addr_lo    = a;
        size_code  = s;
        mem_sel    = m;
        alu_result = alu;
        @(negedge clk);
    endtask

    function automatic logic [63:0] expect_val(input logic [63:0] c, input logic [2:0] a,
                                               input logic [1:0] s, input logic m,
                                               input logic [63:0] alu);
        logic [63:0] w;
        logic [63:0] b;
        if (!m) return alu;
        w = (c >> (32 * a[2])) & 64'h0000_0000_FFFF_FFFF;
        if (w[31]) w = w | 64'hFFFF_FFFF_0000_0000;
        b = (c >> (8 * a)) & 64'hFF;
        if (b[7]) b = b | 64'hFFFF_FFFF_FFFF_FF00;
        case (s)
            2'b11:   return c;
            2'b10:   return w;
            2'b00:   return b;
            default: return 64'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a, input logic [1:0] s, input logic m);
        if (!m) return "R7";
        case (s)
            2'b11: return "R1";
            2'b01: return "R6";
            2'b00: return "R5";
            default: begin
                if (a[1:0] != 2'b00) return "R8";
                return a[2] ? "R3" : "R2";
            end
        endcase
    endfunction

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] pats [12];
        logic [63:0] rng;
        pats[0] = 64'hFFFF_8000_0000_0007;
        pats[1] = 64'h0123_4567_89AB_CDEF;
        pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[3] = 64'h0000_0000_0000_0000;
        pats[4] = 64'h807F_807F_7F80_7F80;
        pats[5] = 64'h7FFF_FFFF_8000_0000;
        rng = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 6; i < 12; i++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 7);
            rng = rng ^ (rng << 17);
            pats[i] = rng;
        end

        // Idle state: all-zero inputs give a zero result.
        apply('0, '0, '0, 1'b0, '0);
        compare("R7 idle", wb_data, 64'h0);

        // R9 worked examples, R4 sign fill on the upper word.
        apply(64'hFFFF_8000_0000_0007, 3'd4, 2'b10, 1'b1, 64'h1);
        compare("R9 word at offset 4", wb_data, 64'hFFFF_FFFF_FFFF_8000);
        compare("R4 sign fill", {32'h0, wb_data[63:32]}, 64'h0000_0000_FFFF_FFFF);
        apply(64'hFFFF_8000_0000_0007, 3'd0, 2'b10, 1'b1, 64'h1);
        compare("R9 word at offset 0", wb_data, 64'h7);

        // Full sweep over patterns, offsets, sizes and selector.
        for (int p = 0; p < 12; p++) begin
            for (int a = 0; a < 8; a++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int m = 0; m < 2; m++) begin
                        logic [63:0] alu;
                        alu = ~pats[p] ^ (64'h5A5A_0000_0000_0000 + 64'(a * 4 + s));
                        apply(pats[p], 3'(a), 2'(s), 1'(m), alu);
                        compare(tag_of(3'(a), 2'(s), 1'(m)), wb_data,
                                expect_val(pats[p], 3'(a), 2'(s), 1'(m), alu));
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule